// File: doc/BRIEF.md
# Audio Interface Global Control Registers

This block holds the global control and status words of a streaming audio interface. It keeps a 64-bit owner address, which is a node ID in bits 63:48 with an offset below it. It also keeps the most recent set of asynchronous events, the clock selection, the streaming enable and live clock status. A host reaches these registers through a simple quadlet-indexed request port. The port supports reads, writes and a 64-bit compare-and-swap. Every request is answered one cycle later. No real bus transaction logic is part of this block.

Whenever events occur, the block records them and reports them as a write to the owner's address. The events are a configuration change, a lock change, an accepted clock select, or a change in any source's lock. The report leaves on a valid/ready notification port. `ntf_valid` stays high, and `ntf_addr`/`ntf_data` stay unchanged, until `ntf_ready` is seen high at a clock edge. Events that arrive while a report is waiting are merged and sent as one further report once the waiting one is taken. While no owner is registered, events are still recorded, but nothing is sent.

Register indices (quadlets) used by the request port: 0 owner high word, 1 owner low word, 2 event word, 3 clock select, 4 stream enable, 5 clock status, 6 per-source status. Operations: 0 read, 1 write, 2 compare-swap, 3 no effect.

Top module: `aif_global_regs`

## Requirements
- R1: After reset the owner reads 0xFFFF0000 (index 0) and 0x00000000 (index 1), which is the no-owner value 0xFFFF000000000000. The event word reads 0, clock select reads 0x020C, enable reads 0, and `ntf_valid` is low.
- R2: The owner changes only through a compare-swap (op 2) at index 0. The swap value is stored only when the compare value equals the current owner. The response carries the previous 64-bit owner. Ordinary writes to indices 0 and 1 are ignored.
- R3: A `bus_reset` pulse returns the owner to no-owner and clears the enable. It also discards events merged but not yet sent.
- R4: In any cycle with at least one event, the event word is replaced by exactly that cycle's events. The bit codes are: receive config 0x01, transmit config 0x02, current-source lock change 0x10, clock select accepted 0x20, per-source lock change 0x40.
- R5: With an owner registered and the notification port idle, an event launches a notification in the next cycle. Its address is the owner value and its data is the event bits.
- R6: A waiting notification holds its address and data until accepted. Events arriving meanwhile are ORed together and sent as the next notification once it is accepted.
- R7: While the owner is no-owner, events still update the event word but no notification is issued.
- R8: A write to index 3 stores data bits 15:0. Bits 7:0 are the source and bits 15:8 the rate code. Upper bits read back as 0, and the write raises event 0x20.
- R9: A write to index 4 sets the enable to 1 for any non-zero value and to 0 for zero.
- R10: Index 6 bits 10:0 show the live per-source lock inputs, and any change in them raises 0x40. A change of `cur_lock` raises 0x10.
- R11: Index 6 bits 26:16 are sticky slip flags and raise no event. A plain read (`req_block` low) returns them and then clears them. A read with `req_block` high leaves them set.
- R12: Index 5 reads `cur_lock` in bit 0 and `nominal_rate` in bits 15:8. Writes to read-only indices have no effect, and unmapped indices read 0.
- R13: `rsp_valid` is high in exactly the cycle after each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bus_reset | input | 1 | bus reset pulse |
| req_valid | input | 1 | register request present |
| req_op | input | 2 | 0 read, 1 write, 2 compare-swap |
| req_addr | input | 4 | quadlet index |
| req_block | input | 1 | read is part of a block read |
| req_wdata | input | 32 | write data |
| req_cmp | input | 64 | compare value for compare-swap |
| req_swap | input | 64 | new value for compare-swap |
| rsp_valid | output | 1 | response present |
| rsp_data | output | 64 | read data (low word) or previous owner |
| cur_lock | input | 1 | lock of the selected clock source |
| nominal_rate | input | 8 | rate code of the recovered clock |
| src_lock | input | 11 | lock state per clock source |
| src_slip | input | 11 | slip pulses per clock source |
| ev_rx_cfg | input | 1 | receive configuration changed strobe |
| ev_tx_cfg | input | 1 | transmit configuration changed strobe |
| ntf_valid | output | 1 | notification write pending |
| ntf_ready | input | 1 | notification write accepted |
| ntf_addr | output | 64 | notification target address |
| ntf_data | output | 32 | notification event bits |

## Verification
The assertions assume that `ntf_ready` may toggle freely and that `bus_reset` is a pulse applied between requests. They also assume that at most one request is presented per cycle. The stimulus respects these limits: it applies one request per cycle and lowers `req_valid` between accesses. It gives `bus_reset` only on idle request cycles, and it holds `ntf_ready` low while merging behaviour is being observed.

// File: rtl/aif_regs_pkg.sv
package aif_regs_pkg;
  localparam int QW = 32;
  localparam int OW = 64;
  localparam logic [OW-1:0] OWNER_NONE = 64'hFFFF_0000_0000_0000;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_CSWAP = 2'd2,
    OP_NONE  = 2'd3
  } reg_op_e;

  localparam logic [3:0] IX_OWN_HI = 4'd0;
  localparam logic [3:0] IX_OWN_LO = 4'd1;
  localparam logic [3:0] IX_EVENT  = 4'd2;
  localparam logic [3:0] IX_CLKSEL = 4'd3;
  localparam logic [3:0] IX_ENABLE = 4'd4;
  localparam logic [3:0] IX_STATUS = 4'd5;
  localparam logic [3:0] IX_SRCSTS = 4'd6;

  localparam int EVB_RX     = 0;
  localparam int EVB_TX     = 1;
  localparam int EVB_LOCK   = 4;
  localparam int EVB_ACCEPT = 5;
  localparam int EVB_SRC    = 6;

  localparam logic [15:0] CLKSEL_RST = 16'h020C;
  localparam int SLIP_LSB = 16;
endpackage

// File: rtl/aif_evt_detect.sv
module aif_evt_detect
  import aif_regs_pkg::*;
#(
  parameter int NSRC = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cur_lock,
  input  logic [NSRC-1:0] src_lock,
  input  logic            ev_rx_cfg,
  input  logic            ev_tx_cfg,
  input  logic            clk_wr,
  output logic [QW-1:0]   ev_vec
);
  logic            cur_q;
  logic [NSRC-1:0] src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= 1'b0;
      src_q <= '0;
    end else begin
      cur_q <= cur_lock;
      src_q <= src_lock;
    end
  end

  always_comb begin
    ev_vec             = '0;
    ev_vec[EVB_RX]     = ev_rx_cfg;
    ev_vec[EVB_TX]     = ev_tx_cfg;
    ev_vec[EVB_LOCK]   = cur_lock != cur_q;
    ev_vec[EVB_ACCEPT] = clk_wr;
    ev_vec[EVB_SRC]    = src_lock != src_q;
  end
endmodule

// File: rtl/aif_slip_track.sv
module aif_slip_track #(
  parameter int NSRC = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] slip_in,
  input  logic            clr,
  output logic [NSRC-1:0] sticky
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sticky[i] <= 1'b0;
      else if (slip_in[i]) sticky[i] <= 1'b1;
      else if (clr)        sticky[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/aif_notify_tx.sv
module aif_notify_tx
  import aif_regs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_reset,
  input  logic [QW-1:0] ev,
  input  logic [OW-1:0] owner,
  output logic          ntf_valid,
  input  logic          ntf_ready,
  output logic [OW-1:0] ntf_addr,
  output logic [QW-1:0] ntf_data
);
  logic [QW-1:0] pend_q;
  logic [QW-1:0] send_mask;
  logic          slot_free;
  logic          owner_ok;

  assign slot_free = !ntf_valid || ntf_ready;
  assign send_mask = pend_q | ev;
  assign owner_ok  = owner != OWNER_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ntf_valid <= 1'b0;
      ntf_addr  <= '0;
      ntf_data  <= '0;
      pend_q    <= '0;
    end else if (slot_free) begin
      pend_q <= '0;
      if (!bus_reset && owner_ok && (|send_mask)) begin
        ntf_valid <= 1'b1;
        ntf_data  <= send_mask;
        ntf_addr  <= owner;
      end else begin
        ntf_valid <= 1'b0;
      end
    end else begin
      pend_q <= bus_reset ? '0 : (pend_q | ev);
    end
  end
endmodule

// File: rtl/aif_global_regs.sv
module aif_global_regs
  import aif_regs_pkg::*;
#(
  parameter int NSRC = 11,
  parameter int AW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_reset,
  input  logic            req_valid,
  input  logic [1:0]      req_op,
  input  logic [AW-1:0]   req_addr,
  input  logic            req_block,
  input  logic [31:0]     req_wdata,
  input  logic [63:0]     req_cmp,
  input  logic [63:0]     req_swap,
  output logic            rsp_valid,
  output logic [63:0]     rsp_data,
  input  logic            cur_lock,
  input  logic [7:0]      nominal_rate,
  input  logic [NSRC-1:0] src_lock,
  input  logic [NSRC-1:0] src_slip,
  input  logic            ev_rx_cfg,
  input  logic            ev_tx_cfg,
  output logic            ntf_valid,
  input  logic            ntf_ready,
  output logic [63:0]     ntf_addr,
  output logic [31:0]     ntf_data
);
  localparam int CSW = 16;

  logic [OW-1:0]   owner_q;
  logic [QW-1:0]   evt_q;
  logic [CSW-1:0]  clksel_q;
  logic            en_q;
  logic [QW-1:0]   ev_vec;
  logic [NSRC-1:0] slip_q;
  logic [QW-1:0]   src_word;
  logic [QW-1:0]   rd_word;
  logic            wr_hit, clk_wr, en_wr, cswap_hit, slip_clr;

  assign wr_hit    = req_valid && (req_op == OP_WRITE);
  assign clk_wr    = wr_hit && (req_addr == AW'(IX_CLKSEL));
  assign en_wr     = wr_hit && (req_addr == AW'(IX_ENABLE));
  assign cswap_hit = req_valid && (req_op == OP_CSWAP) && (req_addr == AW'(IX_OWN_HI));
  assign slip_clr  = req_valid && (req_op == OP_READ) && !req_block
                     && (req_addr == AW'(IX_SRCSTS));

  aif_evt_detect #(.NSRC(NSRC)) u_evt (
    .clk(clk), .rst_n(rst_n), .cur_lock(cur_lock), .src_lock(src_lock),
    .ev_rx_cfg(ev_rx_cfg), .ev_tx_cfg(ev_tx_cfg), .clk_wr(clk_wr), .ev_vec(ev_vec)
  );

  aif_slip_track #(.NSRC(NSRC)) u_slip (
    .clk(clk), .rst_n(rst_n), .slip_in(src_slip), .clr(slip_clr), .sticky(slip_q)
  );

  aif_notify_tx u_ntf (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .ev(ev_vec), .owner(owner_q),
    .ntf_valid(ntf_valid), .ntf_ready(ntf_ready), .ntf_addr(ntf_addr), .ntf_data(ntf_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 owner_q <= OWNER_NONE;
    else if (bus_reset)                         owner_q <= OWNER_NONE;
    else if (cswap_hit && (req_cmp == owner_q)) owner_q <= req_swap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q    <= '0;
      clksel_q <= CLKSEL_RST;
      en_q     <= 1'b0;
    end else begin
      if (|ev_vec) evt_q <= ev_vec;
      if (clk_wr)  clksel_q <= req_wdata[CSW-1:0];
      if (bus_reset)  en_q <= 1'b0;
      else if (en_wr) en_q <= |req_wdata;
    end
  end

  always_comb begin
    src_word                      = '0;
    src_word[NSRC-1:0]            = src_lock;
    src_word[SLIP_LSB +: NSRC]    = slip_q;
  end

  always_comb begin
    rd_word = '0;
    case (req_addr)
      AW'(IX_OWN_HI): rd_word = owner_q[63:32];
      AW'(IX_OWN_LO): rd_word = owner_q[31:0];
      AW'(IX_EVENT):  rd_word = evt_q;
      AW'(IX_CLKSEL): rd_word = {{(QW-CSW){1'b0}}, clksel_q};
      AW'(IX_ENABLE): rd_word = {{(QW-1){1'b0}}, en_q};
      AW'(IX_STATUS): rd_word = {16'h0000, nominal_rate, 7'b0000000, cur_lock};
      AW'(IX_SRCSTS): rd_word = src_word;
      default:        rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        case (req_op)
          OP_READ:  rsp_data <= {32'h0, rd_word};
          OP_CSWAP: rsp_data <= owner_q;
          default:  rsp_data <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/aif_global_regs_chk.sv
module aif_global_regs_chk
  import aif_regs_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        bus_reset,
  input logic        req_valid,
  input logic [1:0]  req_op,
  input logic        rsp_valid,
  input logic        ntf_valid,
  input logic        ntf_ready,
  input logic [63:0] ntf_addr,
  input logic [31:0] ntf_data,
  input logic [63:0] owner_q,
  input logic        en_q
);
  p_rsp_follows_r13: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_rsp_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_ntf_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid && !ntf_ready |=> ntf_valid && $stable(ntf_data) && $stable(ntf_addr));
  p_ntf_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> ntf_data != 32'h0);
  p_no_owner_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ntf_valid || ntf_ready) && owner_q == OWNER_NONE |=> !ntf_valid);
  p_bus_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> owner_q == OWNER_NONE && !en_q);
  p_owner_cswap_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(owner_q) |-> $past(bus_reset || (req_valid && req_op == OP_CSWAP)));
endmodule

bind aif_global_regs aif_global_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .req_valid(req_valid),
  .req_op(req_op), .rsp_valid(rsp_valid), .ntf_valid(ntf_valid),
  .ntf_ready(ntf_ready), .ntf_addr(ntf_addr), .ntf_data(ntf_data),
  .owner_q(owner_q), .en_q(en_q)
);

// File: tb/aif_global_regs_test.sv
module aif_global_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] NONE = 64'hFFFF_0000_0000_0000;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  ix;
    logic [31:0] wd;
    logic        chk;
    logic [31:0] exp;
  } vec_t;

  // Table rows cover R8 (clock select), R9 (enable), R12 (read-only / unmapped), R4 (accept event)
  localparam vec_t VECS [14] = '{
    '{2'd1, 4'd3, 32'hABCD_0406, 1'b0, 32'h0},
    '{2'd0, 4'd3, 32'h0,         1'b1, 32'h0000_0406},
    '{2'd0, 4'd2, 32'h0,         1'b1, 32'h0000_0020},
    '{2'd1, 4'd4, 32'h0000_0005, 1'b0, 32'h0},
    '{2'd0, 4'd4, 32'h0,         1'b1, 32'h0000_0001},
    '{2'd1, 4'd4, 32'h0,         1'b0, 32'h0},
    '{2'd0, 4'd4, 32'h0,         1'b1, 32'h0},
    '{2'd1, 4'd5, 32'hFFFF_FFFF, 1'b0, 32'h0},
    '{2'd0, 4'd5, 32'h0,         1'b1, 32'h0},
    '{2'd1, 4'd1, 32'h0000_1234, 1'b0, 32'h0},
    '{2'd0, 4'd1, 32'h0,         1'b1, 32'h0},
    '{2'd0, 4'd15, 32'h0,        1'b1, 32'h0},
    '{2'd1, 4'd3, 32'h0000_0A0C, 1'b0, 32'h0},
    '{2'd0, 4'd3, 32'h0,         1'b1, 32'h0000_0A0C}
  };

  logic clk = 1'b0, rst_n = 1'b0, bus_reset = 1'b0;
  logic req_valid = 1'b0, req_block = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [3:0] req_addr = 4'd0;
  logic [31:0] req_wdata = '0;
  logic [63:0] req_cmp = '0, req_swap = '0;
  logic rsp_valid;
  logic [63:0] rsp_data;
  logic cur_lock = 1'b0;
  logic [7:0] nominal_rate = 8'd0;
  logic [10:0] src_lock = '0, src_slip = '0;
  logic ev_rx_cfg = 1'b0, ev_tx_cfg = 1'b0;
  logic ntf_valid, ntf_ready = 1'b0;
  logic [63:0] ntf_addr;
  logic [31:0] ntf_data;

  int n_chk = 0, n_fail = 0;
  logic [63:0] rd;
  logic rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  aif_global_regs uut (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] op, input logic [3:0] ix, input logic [31:0] wd,
                        input logic [63:0] cmp, input logic [63:0] sw, input logic blk);
    req_valid = 1'b1; req_op = op; req_addr = ix; req_wdata = wd;
    req_cmp = cmp; req_swap = sw; req_block = blk;
    @(negedge clk);
    req_valid = 1'b0; req_block = 1'b0;
    rd = rsp_data; rv = rsp_valid;
  endtask

  task automatic rd_chk(input logic [3:0] ix, input logic [31:0] exp, input string tag);
    access(2'd0, ix, 32'h0, 64'h0, 64'h0, 1'b0);
    check(tag, rd, {32'h0, exp});
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check("R1 ntf_valid", {63'h0, ntf_valid}, 64'h0);
    rd_chk(4'd0, 32'hFFFF_0000, "R1 owner hi");
    check("R13 rsp_valid after request", {63'h0, rv}, 64'h1);
    tick();
    check("R13 rsp_valid idle", {63'h0, rsp_valid}, 64'h0);
    rd_chk(4'd1, 32'h0, "R1 owner lo");
    rd_chk(4'd2, 32'h0, "R1 events");
    rd_chk(4'd3, 32'h0000_020C, "R1 clksel");
    rd_chk(4'd4, 32'h0, "R1 enable");

    for (int i = 0; i < 14; i++) begin
      access(VECS[i].op, VECS[i].ix, VECS[i].wd, 64'h0, 64'h0, 1'b0);
      if (VECS[i].chk) check($sformatf("R8/R9/R12/R4 row %0d", i), rd, {32'h0, VECS[i].exp});
    end
    check("R7 no write while no owner", {63'h0, ntf_valid}, 64'h0);

    // R2 compare-swap
    access(2'd2, 4'd0, 32'h0, 64'h0, 64'h1234, 1'b0);
    check("R2 cswap miss returns old", rd, NONE);
    rd_chk(4'd0, 32'hFFFF_0000, "R2 owner kept on miss");
    access(2'd2, 4'd0, 32'h0, NONE, 64'h0002_0000_0000_4000, 1'b0);
    check("R2 cswap hit returns old", rd, NONE);
    rd_chk(4'd0, 32'h0002_0000, "R2 owner hi swapped");
    rd_chk(4'd1, 32'h0000_4000, "R2 owner lo swapped");

    // R5 notification launch
    ev_rx_cfg = 1'b1; tick(); ev_rx_cfg = 1'b0;
    check("R5 ntf_valid", {63'h0, ntf_valid}, 64'h1);
    check("R5 ntf_addr", ntf_addr, 64'h0002_0000_0000_4000);
    check("R5 ntf_data", {32'h0, ntf_data}, 64'h1);
    rd_chk(4'd2, 32'h1, "R4 event word rx");
    // R6 merging while held
    ev_tx_cfg = 1'b1; tick(); ev_tx_cfg = 1'b0;
    check("R6 data held", {32'h0, ntf_data}, 64'h1);
    rd_chk(4'd2, 32'h2, "R4 event word replaced");
    cur_lock = 1'b1; tick();
    rd_chk(4'd2, 32'h10, "R10 current lock change");
    ntf_ready = 1'b1; tick(); ntf_ready = 1'b0;
    check("R6 merged valid", {63'h0, ntf_valid}, 64'h1);
    check("R6 merged data", {32'h0, ntf_data}, 64'h12);
    ntf_ready = 1'b1; tick(); ntf_ready = 1'b0;
    check("R6 drained", {63'h0, ntf_valid}, 64'h0);

    // R10 per-source lock
    src_lock = 11'h008; tick();
    check("R10 src lock notify", {32'h0, ntf_data}, 64'h40);
    rd_chk(4'd6, 32'h0000_0008, "R10 live lock bits");
    ntf_ready = 1'b1; tick(); ntf_ready = 1'b0;

    // R11 sticky slips
    src_slip = 11'h004; tick(); src_slip = 11'h000;
    check("R11 slip raises no notify", {63'h0, ntf_valid}, 64'h0);
    rd_chk(4'd2, 32'h40, "R11 slip leaves event word");
    access(2'd0, 4'd6, 32'h0, 64'h0, 64'h0, 1'b1);
    check("R11 block read sees slip", rd, 64'h0004_0008);
    rd_chk(4'd6, 32'h0004_0008, "R11 quadlet read sees slip");
    rd_chk(4'd6, 32'h0000_0008, "R11 slip cleared");

    // R12 status
    nominal_rate = 8'h04; tick();
    rd_chk(4'd5, 32'h0000_0401, "R12 status word");

    // R3 bus reset
    access(2'd1, 4'd4, 32'h1, 64'h0, 64'h0, 1'b0);
    ntf_ready = 1'b1; tick(); ntf_ready = 1'b0;
    bus_reset = 1'b1; tick(); bus_reset = 1'b0;
    rd_chk(4'd4, 32'h0, "R3 enable cleared");
    rd_chk(4'd0, 32'hFFFF_0000, "R3 owner cleared");
    ev_rx_cfg = 1'b1; tick(); ev_rx_cfg = 1'b0;
    check("R7 no write after bus reset", {63'h0, ntf_valid}, 64'h0);
    rd_chk(4'd2, 32'h1, "R7 event still latched");

    // R3 pending dropped by bus reset
    access(2'd2, 4'd0, 32'h0, NONE, 64'h0003_0000_0000_0100, 1'b0);
    ev_rx_cfg = 1'b1; tick(); ev_rx_cfg = 1'b0;
    ev_tx_cfg = 1'b1; tick(); ev_tx_cfg = 1'b0;
    bus_reset = 1'b1; tick(); bus_reset = 1'b0;
    check("R3 in-flight kept", {32'h0, ntf_data}, 64'h1);
    ntf_ready = 1'b1; tick(); ntf_ready = 1'b0;
    check("R3 pending discarded", {63'h0, ntf_valid}, 64'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule